// File: doc/BRIEF.md
# Static Memory Read Timing Sequencer

This block runs read cycles on an external asynchronous static memory that is split over several chip-select banks. Each bank has two timing fields of its own. The setup delay sets how many bus-clock cycles pass with address and chip select driven before output-enable goes low. The access delay sets how long output-enable then stays low. One fixed hold cycle always ends the cycle, so a read lasts setup + (access + 1) + 1 cycles, and the address and chip select stay valid for all of it.

A requester asks for a read with a bank, a word address and a burst flag. In burst mode only the first beat pays the full access delay. Each later beat inside the same aligned four-word page takes one cycle, and output-enable stays low between beats. The burst ends when the flag is low at the end of a beat or when the word just read is the last one of its page. Timing fields can only change while no read is in flight. A busy status bit can be read through the register port.

Top module: `sram_read_sequencer`

## Requirements
- R1: After reset all chip selects and output-enable are high, rsp_valid is 0 and req_ready is 1. Every setup field reads back as 15 and every access field reads back as 31.
- R2: Bank b has its registers at byte address 0x20*b: the setup field is in bits 3:0 at offset 0x00, and the access field is in bits 4:0 at offset 0x04. Unused bits and all other offsets in a bank's window read 0. The status word at 0x80 holds busy in bit 0.
- R3: A non-burst read keeps the selected chip select low for exactly setup + access + 2 cycles. The address stays constant for that whole time.
- R4: After a request is accepted, output-enable stays high for the first setup cycles, then goes low for access + 1 cycles, then stays high for the final hold cycle while chip select is still low.
- R5: Data is captured from mem_din on the last cycle that output-enable is low. rsp_valid is high for one cycle right after that, with the captured word on rsp_data.
- R6: With setup = 0 and access = 0, a read takes two cycles: one with output-enable low and one hold cycle.
- R7: In burst mode, each later beat of a burst takes one cycle with output-enable held low, the address goes up by one, and each beat gives its own response.
- R8: A burst never passes an aligned four-word page: it stops after the word whose address bits 1:0 equal 3, even while req_burst is high.
- R9: A register write made while a read is in flight has no effect, and the busy bit reads 1 during the read and 0 afterwards.
- R10: req_ready is high only while no read is in flight, and requests are accepted only then.
- R11: At most one chip select is low at any time, and it is the one for the bank that was requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| req_valid | input | 1 | Read request |
| req_ready | output | 1 | High when a request is accepted this cycle |
| req_bank | input | 2 | Bank of the request |
| req_addr | input | 16 | Word address of the request |
| req_burst | input | 1 | Continue with page beats while high |
| rsp_valid | output | 1 | One-cycle pulse per returned word |
| rsp_data | output | 16 | Returned word |
| mem_addr | output | 16 | Memory address |
| mem_cs_n | output | 4 | Active-low chip selects, one per bank |
| mem_oe_n | output | 1 | Active-low output-enable |
| mem_din | input | 16 | Data from memory |

## Verification
A counter that is off by one shows up within one read as a setup phase, an output-enable-low phase or a chip-select phase that is one cycle too long or too short. The bench measures each of these phases separately at the ports. The bench memory returns a marker word whenever output-enable is high, so data sampled one cycle late gives a wrong response in that same read. A page counter or burst decision in the wrong state changes the number of response pulses and the words they carry. A write that gets through while busy shows up in the readback value and in the length of the next read.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_HOLD   = 2'd3
  } rd_state_e;

  localparam int unsigned BANK_STRIDE = 32;
  localparam logic [2:0]  WORD_SETUP  = 3'd0;
  localparam logic [2:0]  WORD_ACCESS = 3'd1;
endpackage

// File: rtl/srt_timing_regs.sv
module srt_timing_regs
  import srt_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int OEW   = 4,
  parameter int RDW   = 5,
  parameter int CAW   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      busy,
  input  logic [CAW-1:0]            addr,
  input  logic [31:0]               wdata,
  output logic [31:0]               rdata,
  output logic [NBANK-1:0][OEW-1:0] setup_tab,
  output logic [NBANK-1:0][RDW-1:0] access_tab
);
  localparam int BSELW = $clog2(NBANK);
  localparam int MAXW  = (OEW > RDW) ? OEW : RDW;
  localparam logic [CAW-1:0] STATUS_OFS = CAW'(NBANK * BANK_STRIDE);

  logic             in_banks;
  logic [BSELW-1:0] bank_idx;
  logic [2:0]       word_idx;
  logic             wr_ok;
  logic             unused_bits;

  assign in_banks    = addr < STATUS_OFS;
  assign bank_idx    = addr[5 +: BSELW];
  assign word_idx    = addr[4:2];
  assign wr_ok       = wr_en & ~busy & in_banks;
  assign unused_bits = ^{wdata[31:MAXW], addr[1:0]};

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic           hit;
    logic           setup_en, access_en;
    logic [OEW-1:0] setup_q;
    logic [RDW-1:0] access_q;

    assign hit       = wr_ok && (bank_idx == BSELW'(b));
    assign setup_en  = hit && (word_idx == WORD_SETUP);
    assign access_en = hit && (word_idx == WORD_ACCESS);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        setup_q  <= '1;
        access_q <= '1;
      end else begin
        if (setup_en)  setup_q  <= wdata[OEW-1:0];
        if (access_en) access_q <= wdata[RDW-1:0];
      end
    end

    assign setup_tab[b]  = setup_q;
    assign access_tab[b] = access_q;
  end

  always_comb begin
    rdata = '0;
    if (in_banks) begin
      for (int b = 0; b < NBANK; b++) begin
        if (bank_idx == BSELW'(b)) begin
          if (word_idx == WORD_SETUP)  rdata[OEW-1:0] = setup_tab[b];
          if (word_idx == WORD_ACCESS) rdata[RDW-1:0] = access_tab[b];
        end
      end
    end else if (addr == STATUS_OFS) begin
      rdata[0] = busy;
    end
  end
endmodule

// File: rtl/srt_read_fsm.sv
module srt_read_fsm
  import srt_pkg::*;
#(
  parameter int NBANK      = 4,
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int OEW        = 4,
  parameter int RDW        = 5,
  parameter int PAGE_WORDS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [$clog2(NBANK)-1:0]  req_bank,
  input  logic [AW-1:0]             req_addr,
  input  logic                      req_burst,
  input  logic [NBANK-1:0][OEW-1:0] setup_tab,
  input  logic [NBANK-1:0][RDW-1:0] access_tab,
  input  logic [DW-1:0]             mem_din,
  output logic                      req_ready,
  output logic                      busy,
  output logic [AW-1:0]             mem_addr,
  output logic [NBANK-1:0]          mem_cs_n,
  output logic                      mem_oe_n,
  output logic                      rsp_valid,
  output logic [DW-1:0]             rsp_data
);
  localparam int BSELW = $clog2(NBANK);
  localparam int PGW   = $clog2(PAGE_WORDS);
  localparam int CW    = (OEW > RDW) ? OEW : RDW;

  rd_state_e        state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [BSELW-1:0] bank_q, bank_d;
  logic             ld_en, cap_en;
  logic             rsp_valid_q, rsp_valid_d;
  logic [DW-1:0]    rsp_data_q;
  logic [OEW-1:0]   setup_new;
  logic [RDW-1:0]   access_new, access_cur;
  logic             page_last;

  assign setup_new  = setup_tab[req_bank];
  assign access_new = access_tab[req_bank];
  assign access_cur = access_tab[bank_q];
  assign page_last  = addr_q[PGW-1:0] == PGW'(PAGE_WORDS - 1);

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    addr_d      = addr_q;
    bank_d      = bank_q;
    ld_en       = 1'b0;
    cap_en      = 1'b0;
    rsp_valid_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_en  = 1'b1;
          addr_d = req_addr;
          bank_d = req_bank;
          if (setup_new != '0) begin
            state_d = ST_SETUP;
            cnt_d   = CW'(setup_new) - CW'(1);
          end else begin
            state_d = ST_ACCESS;
            cnt_d   = CW'(access_new);
          end
        end
      end
      ST_SETUP: begin
        if (cnt_q == '0) begin
          state_d = ST_ACCESS;
          cnt_d   = CW'(access_cur);
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_ACCESS: begin
        if (cnt_q == '0) begin
          cap_en      = 1'b1;
          rsp_valid_d = 1'b1;
          if (req_burst && !page_last) begin
            ld_en  = 1'b1;
            addr_d = addr_q + AW'(1);
          end else begin
            state_d = ST_HOLD;
          end
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_HOLD: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      addr_q      <= '0;
      bank_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      rsp_valid_q <= rsp_valid_d;
      if (ld_en) begin
        addr_q <= addr_d;
        bank_q <= bank_d;
      end
      if (cap_en) rsp_data_q <= mem_din;
    end
  end

  assign busy      = state_q != ST_IDLE;
  assign req_ready = ~busy;
  assign mem_oe_n  = state_q != ST_ACCESS;
  assign mem_addr  = addr_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_cs
    assign mem_cs_n[b] = ~(busy && (bank_q == BSELW'(b)));
  end
endmodule

// File: rtl/sram_read_sequencer.sv
module sram_read_sequencer
  import srt_pkg::*;
#(
  parameter int NBANK      = 4,
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int OEW        = 4,
  parameter int RDW        = 5,
  parameter int PAGE_WORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [7:0]               cfg_addr,
  input  logic [31:0]              cfg_wdata,
  output logic [31:0]              cfg_rdata,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [$clog2(NBANK)-1:0] req_bank,
  input  logic [AW-1:0]            req_addr,
  input  logic                     req_burst,
  output logic                     rsp_valid,
  output logic [DW-1:0]            rsp_data,
  output logic [AW-1:0]            mem_addr,
  output logic [NBANK-1:0]         mem_cs_n,
  output logic                     mem_oe_n,
  input  logic [DW-1:0]            mem_din
);
  logic [1:0]                rst_sync_q;
  logic                      rst_n_int;
  logic                      busy;
  logic [NBANK-1:0][OEW-1:0] setup_tab;
  logic [NBANK-1:0][RDW-1:0] access_tab;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  srt_timing_regs #(
    .NBANK(NBANK), .OEW(OEW), .RDW(RDW), .CAW(8)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en     (cfg_we),
    .busy      (busy),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .setup_tab (setup_tab),
    .access_tab(access_tab)
  );

  srt_read_fsm #(
    .NBANK(NBANK), .AW(AW), .DW(DW), .OEW(OEW), .RDW(RDW), .PAGE_WORDS(PAGE_WORDS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req_valid (req_valid),
    .req_bank  (req_bank),
    .req_addr  (req_addr),
    .req_burst (req_burst),
    .setup_tab (setup_tab),
    .access_tab(access_tab),
    .mem_din   (mem_din),
    .req_ready (req_ready),
    .busy      (busy),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/sram_read_sequencer_chk.sv
module sram_read_sequencer_chk #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NBANK-1:0] mem_cs_n,
  input logic             mem_oe_n,
  input logic             rsp_valid,
  input logic             req_ready
);
  p_cs_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));

  p_oe_inside_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !(&mem_cs_n));

  p_hold_after_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> !(&mem_cs_n));

  p_rsp_after_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !$past(mem_oe_n));

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ((&mem_cs_n) && mem_oe_n));
endmodule

bind sram_read_sequencer sram_read_sequencer_chk #(.NBANK(NBANK)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_cs_n (mem_cs_n),
  .mem_oe_n (mem_oe_n),
  .rsp_valid(rsp_valid),
  .req_ready(req_ready)
);

// File: tb/sram_read_sequencer_test.sv
module sram_read_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        req_valid, req_ready, req_burst;
  logic [1:0]  req_bank;
  logic [15:0] req_addr;
  logic        rsp_valid;
  logic [15:0] rsp_data, mem_addr, mem_din;
  logic [3:0]  mem_cs_n;
  logic        mem_oe_n;

  int checks = 0;
  int errs   = 0;

  localparam logic [15:0] PAT = 16'h5A3C;
  // {bank[1:0], setup[3:0], access[4:0], addr[15:0], burst}
  localparam logic [27:0] VECS [0:7] = '{
    {2'd0, 4'd0,  5'd0,  16'h0010, 1'b0},
    {2'd1, 4'd3,  5'd4,  16'h0123, 1'b0},
    {2'd2, 4'd0,  5'd7,  16'h0200, 1'b1},
    {2'd3, 4'd2,  5'd0,  16'h0302, 1'b1},
    {2'd1, 4'd5,  5'd2,  16'h0403, 1'b1},
    {2'd0, 4'd1,  5'd31, 16'h0011, 1'b1},
    {2'd2, 4'd15, 5'd1,  16'h0040, 1'b0},
    {2'd3, 4'd0,  5'd10, 16'h7FFE, 1'b0}
  };

  always #2 clk = ~clk;

  // memory model: marker word unless output-enable is low
  assign mem_din = mem_oe_n ? 16'hDEAD : (mem_addr ^ PAT);

  sram_read_sequencer uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_bank(req_bank), .req_addr(req_addr),
    .req_burst(req_burst), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_din(mem_din)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic run_read(input logic [1:0] b, input logic [15:0] a, input logic burst,
                          output int cs_cnt, output int pre, output int lo,
                          output int beats, output int bad, output int rdy, output int wrong_cs);
    cs_cnt = 0; pre = 0; lo = 0; beats = 0; bad = 0; rdy = 0; wrong_cs = 0;
    @(negedge clk);
    req_valid = 1'b1; req_bank = b; req_addr = a; req_burst = burst;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (&mem_cs_n) break;
      cs_cnt++;
      if (mem_cs_n[b]) wrong_cs++;
      if (req_ready) rdy++;
      if (!mem_oe_n) lo++;
      else if (lo == 0) pre++;
      if (rsp_valid) begin
        if (rsp_data !== ((a + 16'(beats)) ^ PAT)) bad++;
        beats++;
      end
      @(negedge clk);
    end
    req_burst = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cs_cnt, pre, lo, beats, bad, rdy, wcs;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_bank = '0; req_addr = '0; req_burst = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 cs_n", mem_cs_n, 4'hF);
    chk("R1 oe_n", mem_oe_n, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 req_ready", req_ready, 1);
    for (int b = 0; b < 4; b++) begin
      rd_reg(8'(b * 32), d);     chk("R1 setup reset", d, 15);
      rd_reg(8'(b * 32 + 4), d); chk("R1 access reset", d, 31);
    end

    // R2: unused bits and offsets
    wr_reg(8'h24, 32'hFFFF_FFE9);
    rd_reg(8'h24, d); chk("R2 upper bits zero", d, 32'h9);
    wr_reg(8'h20, 32'hFFFF_FFF6);
    rd_reg(8'h20, d); chk("R2 setup field", d, 32'h6);
    rd_reg(8'h28, d); chk("R2 unmapped offset", d, 0);
    rd_reg(8'h84, d); chk("R2 beyond status", d, 0);
    rd_reg(8'h80, d); chk("R2 status idle", d, 0);

    // vector table: R3..R8, R10, R11
    for (int v = 0; v < 8; v++) begin
      logic [1:0]  vb;
      logic [3:0]  vs;
      logic [4:0]  va;
      logic [15:0] vaddr;
      logic        vburst;
      int exp_beats;
      {vb, vs, va, vaddr, vburst} = VECS[v];
      wr_reg(8'(vb * 32), 32'(vs));
      wr_reg(8'(vb * 32 + 4), 32'(va));
      rd_reg(8'(vb * 32), d);     chk("R2 setup readback", d, vs);
      rd_reg(8'(vb * 32 + 4), d); chk("R2 access readback", d, va);
      exp_beats = vburst ? (4 - int'(vaddr[1:0])) : 1;   // R7 R8
      run_read(vb, vaddr, vburst, cs_cnt, pre, lo, beats, bad, rdy, wcs);
      chk("R4 setup cycles", pre, vs);
      chk("R4 oe low cycles", lo, int'(va) + 1 + exp_beats - 1);
      chk("R3 cs cycles", cs_cnt, int'(vs) + int'(va) + 1 + exp_beats);
      chk("R7 R8 beats", beats, exp_beats);
      chk("R5 data", bad, 0);
      chk("R10 ready while busy", rdy, 0);
      chk("R11 bank select", wcs, 0);
    end

    // R6: zero wait state
    wr_reg(8'h00, 0); wr_reg(8'h04, 0);
    run_read(2'd0, 16'h0777, 1'b0, cs_cnt, pre, lo, beats, bad, rdy, wcs);
    chk("R6 total cycles", cs_cnt, 2);
    chk("R6 oe low", lo, 1);
    chk("R6 data", bad, 0);

    // R9: write during a read is ignored
    wr_reg(8'h00, 2); wr_reg(8'h04, 20);
    @(negedge clk);
    req_valid = 1'b1; req_bank = 2'd0; req_addr = 16'h0050; req_burst = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    rd_reg(8'h80, d); chk("R9 busy bit", d, 1);
    chk("R10 ready low", req_ready, 0);
    wr_reg(8'h04, 3);
    wr_reg(8'h00, 9);
    for (int i = 0; i < 100; i++) begin
      if (&mem_cs_n) break;
      @(negedge clk);
    end
    rd_reg(8'h80, d); chk("R9 busy cleared", d, 0);
    rd_reg(8'h04, d); chk("R9 access kept", d, 20);
    rd_reg(8'h00, d); chk("R9 setup kept", d, 2);
    run_read(2'd0, 16'h0050, 1'b0, cs_cnt, pre, lo, beats, bad, rdy, wcs);
    chk("R9 timing kept", cs_cnt, 2 + 20 + 2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule